// File: doc/BRIEF.md
# Two-Wire Target Address Recognizer and Event Controller

This block sits behind the bit-level engine of a two-wire serial target. It watches single-cycle event pulses from that engine: START seen, STOP seen, arbitration lost, and a completed byte. After a START it treats the next byte as an address. The upper seven bits of that byte are compared with a programmed own address. When the general-call enable is set, a byte of 0x00 is also accepted. Once addressed, the block decides whether to acknowledge each later data byte.

Every event that needs software attention sets an interrupt flag. The clock line is held low for as long as that flag is set. One cycle after the flag rises, a status code for the event is posted. At all other times the status output shows a fixed "nothing to report" code. Software clears the flag by writing a one to it, and the clock line is released on the next edge. Address recognition keeps working while the system is in power-down. If a different wake source ends power-down, any half-finished recognition is abandoned and the block returns to idle.

Top module: `twi_tgt_ctrl`

## Requirements
- R1: After a START, a received byte whose bits [7:1] equal `own_addr` while `ack_en`=1 sets `ack_out`=1 and raises an event. The status is 0x60 when bit 0 (direction) is 0 (write) and 0xA8 when bit 0 is 1 (read).
- R2: With `gc_en`=1 and `ack_en`=1, an address byte of exactly 0x00 that does not match the own address sets `ack_out`=1 and raises an event with status 0x70. With `gc_en`=0 the byte 0x00 is ignored: no ack and no event.
- R3: An address that would match while `ack_en`=0 is not acknowledged (`ack_out`=0) and raises no event. The block returns to idle, so a following data byte raises no event either.
- R4: A non-matching address byte gives `ack_out`=0 and no event. Later bytes are ignored until the next START.
- R5: A data byte received while addressed for write sets `ack_out` to `ack_en` and raises an event. The status is 0x80 (ack) or 0x88 (nack) for an own-address write, and 0x90 or 0x98 for a general-call write. After a nack the block is no longer addressed.
- R6: A STOP or a repeated START seen while addressed raises an event with status 0xA0. After a repeated START the next byte is treated as a new address.
- R7: An arbitration-lost pulse raises an event with status 0xA0-independent code 0x38 and returns the block to idle.
- R8: `irq_flag` rises on the edge that takes the event. `status` still reads 0xF8 in the cycle that follows and shows the event code after the next edge.
- R9: While `irq_flag` is 0, `status` reads 0xF8.
- R10: `scl_hold` follows `irq_flag`, and the flag stays set until `flag_clr`=1 is sampled. A clear takes effect on the next edge and releases the clock line. A clear while the flag is already 0 has no effect.
- R11: Address recognition works while `sleep_mode`=1. A `wake_other` pulse during `sleep_mode` abandons any pending recognition and returns the block to idle without an event.
- R12: After reset, `irq_flag`=0, `scl_hold`=0, `ack_out`=0 and `status`=0xF8.
- R13: When pulses coincide, the priority is arbitration lost, then STOP, then START, then the power-down abort, then byte received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 7 | Programmed own address |
| gc_en | input | 1 | Accept the general-call address |
| ack_en | input | 1 | Acknowledge matched addresses and data |
| sleep_mode | input | 1 | System is in power-down |
| wake_other | input | 1 | Pulse: another wake source ended power-down |
| start_det | input | 1 | Pulse: START or repeated START seen |
| stop_det | input | 1 | Pulse: STOP seen |
| arb_lost | input | 1 | Pulse: arbitration lost |
| rx_valid | input | 1 | Pulse: a byte has been received |
| rx_byte | input | 8 | Received byte, valid with rx_valid |
| flag_clr | input | 1 | Software write of one to the flag |
| ack_out | output | 1 | Acknowledge decision for the last byte |
| scl_hold | output | 1 | Hold the clock line low |
| irq_flag | output | 1 | Event flag / interrupt |
| status | output | 8 | Event status code, 0xF8 when none |

## Verification
The assertions assume that every event input is a single-cycle pulse. They also assume that `rx_valid` does not arrive while the flag holds the clock line, because a real bus cannot deliver a byte then. The stimulus drives each pulse for exactly one cycle, away from the active edge. It clears the flag before it presents the next byte. Pulses are made to coincide only in the priority case, which the assertions tolerate.

// File: rtl/twi_tgt_pkg.sv
package twi_tgt_pkg;

    typedef logic [7:0] stat_t;

    localparam stat_t ST_NONE     = 8'hF8;
    localparam stat_t ST_OWN_WR   = 8'h60;
    localparam stat_t ST_OWN_RD   = 8'hA8;
    localparam stat_t ST_GC_ADDR  = 8'h70;
    localparam stat_t ST_DAT_ACK  = 8'h80;
    localparam stat_t ST_DAT_NACK = 8'h88;
    localparam stat_t ST_GCD_ACK  = 8'h90;
    localparam stat_t ST_GCD_NACK = 8'h98;
    localparam stat_t ST_END      = 8'hA0;
    localparam stat_t ST_ARB      = 8'h38;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WR,
        PH_GCW,
        PH_RD
    } phase_t;

    typedef struct packed {
        logic own_hit;
        logic gc_hit;
        logic rd;
    } match_t;

    typedef struct packed {
        logic  valid;
        stat_t code;
    } evt_t;

    function automatic logic is_addressed(phase_t p);
        return (p == PH_WR) || (p == PH_GCW) || (p == PH_RD);
    endfunction

    function automatic stat_t data_code(logic gc, logic ack);
        if (gc) return ack ? ST_GCD_ACK : ST_GCD_NACK;
        return ack ? ST_DAT_ACK : ST_DAT_NACK;
    endfunction

endpackage

// File: rtl/twi_tgt_match.sv
module twi_tgt_match
    import twi_tgt_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   byte_i,
    input  logic [ADDR_W-1:0] own_i,
    input  logic              gc_en_i,
    output match_t            hit_o
);
    localparam int BYTE_W = ADDR_W + 1;

    logic own_eq;
    logic gc_eq;

    assign own_eq = (byte_i[BYTE_W-1:1] == own_i);
    assign gc_eq  = gc_en_i && (byte_i == '0);

    always_comb begin
        hit_o.own_hit = own_eq;
        hit_o.gc_hit  = gc_eq && !own_eq;
        hit_o.rd      = byte_i[0];
    end
endmodule

// File: rtl/twi_tgt_fsm.sv
module twi_tgt_fsm
    import twi_tgt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  match_t hit_i,
    input  logic   rx_valid_i,
    input  logic   start_i,
    input  logic   stop_i,
    input  logic   arb_i,
    input  logic   abort_i,
    input  logic   ack_en_i,
    output evt_t   evt_o,
    output logic   ack_o
);
    phase_t phase_q, phase_d;
    logic   ack_q, ack_d;
    evt_t   evt;

    always_comb begin
        phase_d    = phase_q;
        ack_d      = ack_q;
        evt.valid  = 1'b0;
        evt.code   = ST_NONE;
        if (arb_i) begin
            evt.valid = 1'b1;
            evt.code  = ST_ARB;
            phase_d   = PH_IDLE;
            ack_d     = 1'b0;
        end else if (stop_i) begin
            evt.valid = is_addressed(phase_q);
            evt.code  = ST_END;
            phase_d   = PH_IDLE;
            ack_d     = 1'b0;
        end else if (start_i) begin
            evt.valid = is_addressed(phase_q);
            evt.code  = ST_END;
            phase_d   = PH_ADDR;
            ack_d     = 1'b0;
        end else if (abort_i) begin
            phase_d = PH_IDLE;
            ack_d   = 1'b0;
        end else if (rx_valid_i) begin
            unique case (phase_q)
                PH_ADDR: begin
                    if (hit_i.own_hit && ack_en_i) begin
                        ack_d     = 1'b1;
                        evt.valid = 1'b1;
                        evt.code  = hit_i.rd ? ST_OWN_RD : ST_OWN_WR;
                        phase_d   = hit_i.rd ? PH_RD : PH_WR;
                    end else if (hit_i.gc_hit && ack_en_i) begin
                        ack_d     = 1'b1;
                        evt.valid = 1'b1;
                        evt.code  = ST_GC_ADDR;
                        phase_d   = PH_GCW;
                    end else begin
                        ack_d   = 1'b0;
                        phase_d = PH_IDLE;
                    end
                end
                PH_WR, PH_GCW: begin
                    ack_d     = ack_en_i;
                    evt.valid = 1'b1;
                    evt.code  = data_code(phase_q == PH_GCW, ack_en_i);
                    phase_d   = ack_en_i ? phase_q : PH_IDLE;
                end
                default: ack_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            ack_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            ack_q   <= ack_d;
        end
    end

    assign evt_o = evt;
    assign ack_o = ack_q;

    // R3
    ack_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> $past(ack_en_i));

    // R4
    idle_ignores_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && rx_valid_i && !start_i && !stop_i && !arb_i)
        |=> (phase_q == PH_IDLE && !ack_q));

    // R1
    own_match_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ADDR && rx_valid_i && hit_i.own_hit && ack_en_i &&
         !start_i && !stop_i && !arb_i && !abort_i) |=> ack_q);

    // R13
    arb_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        arb_i |=> (phase_q == PH_IDLE && !ack_q));

    // R11
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_i && !start_i) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/twi_tgt_flag.sv
module twi_tgt_flag
    import twi_tgt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  evt_t  evt_i,
    input  logic  clr_i,
    output logic  irq_o,
    output logic  hold_o,
    output stat_t status_o
);
    logic  irq_q;
    stat_t code_q;
    stat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            code_q <= ST_NONE;
            stat_q <= ST_NONE;
        end else begin
            if (evt_i.valid)
                irq_q <= 1'b1;
            else if (clr_i)
                irq_q <= 1'b0;
            if (evt_i.valid)
                code_q <= evt_i.code;
            stat_q <= irq_q ? code_q : ST_NONE;
        end
    end

    assign irq_o    = irq_q;
    assign hold_o   = irq_q;
    assign status_o = irq_q ? stat_q : ST_NONE;

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr_i) |=> irq_q);

    // R10
    release_on_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && clr_i && !evt_i.valid) |=> !hold_o);

    // R8
    status_lag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> (status_o == ST_NONE));

    // R8
    status_post_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_q) && !clr_i && !evt_i.valid) |=> (status_o == $past(code_q)));
endmodule

// File: rtl/twi_tgt_ctrl.sv
module twi_tgt_ctrl
    import twi_tgt_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              ack_en,
    input  logic              sleep_mode,
    input  logic              wake_other,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              arb_lost,
    input  logic              rx_valid,
    input  logic [ADDR_W:0]   rx_byte,
    input  logic              flag_clr,
    output logic              ack_out,
    output logic              scl_hold,
    output logic              irq_flag,
    output logic [7:0]        status
);
    match_t hit;
    evt_t   evt;
    logic   abort;

    assign abort = sleep_mode & wake_other;

    twi_tgt_match #(.ADDR_W(ADDR_W)) u_match (
        .byte_i  (rx_byte),
        .own_i   (own_addr),
        .gc_en_i (gc_en),
        .hit_o   (hit)
    );

    twi_tgt_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .hit_i      (hit),
        .rx_valid_i (rx_valid),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .arb_i      (arb_lost),
        .abort_i    (abort),
        .ack_en_i   (ack_en),
        .evt_o      (evt),
        .ack_o      (ack_out)
    );

    twi_tgt_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .clr_i    (flag_clr),
        .irq_o    (irq_flag),
        .hold_o   (scl_hold),
        .status_o (status)
    );
endmodule

// File: tb/twi_tgt_ctrl_tb.sv
module twi_tgt_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic       gc_en = 1'b0;
    logic       ack_en = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       wake_other = 1'b0;
    logic       start_det = 1'b0;
    logic       stop_det = 1'b0;
    logic       arb_lost = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       flag_clr = 1'b0;
    logic       ack_out;
    logic       scl_hold;
    logic       irq_flag;
    logic [7:0] status;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    twi_tgt_ctrl dut_i (
        .clk(clk), .rst(rst), .own_addr(own_addr), .gc_en(gc_en),
        .ack_en(ack_en), .sleep_mode(sleep_mode), .wake_other(wake_other),
        .start_det(start_det), .stop_det(stop_det), .arb_lost(arb_lost),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .flag_clr(flag_clr),
        .ack_out(ack_out), .scl_hold(scl_hold), .irq_flag(irq_flag),
        .status(status)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) start_det = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_det = 1'b1;
        @(negedge clk) stop_det = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic clear_flag(input string tag);
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        chk({tag, " R10 flag cleared"}, {7'd0, irq_flag}, 8'd0);
        chk({tag, " R10 hold released"}, {7'd0, scl_hold}, 8'd0);
        chk({tag, " R9 status none"}, status, 8'hF8);
    endtask

    task automatic expect_evt(input string tag, input logic [7:0] code);
        chk({tag, " flag set"}, {7'd0, irq_flag}, 8'd1);
        chk({tag, " R10 hold"}, {7'd0, scl_hold}, 8'd1);
        chk({tag, " R8 status lag"}, status, 8'hF8);
        @(negedge clk);
        chk({tag, " R8 status code"}, status, code);
    endtask

    task automatic expect_none(input string tag);
        chk({tag, " no flag"}, {7'd0, irq_flag}, 8'd0);
        chk({tag, " R9 status none"}, status, 8'hF8);
        chk({tag, " no hold"}, {7'd0, scl_hold}, 8'd0);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 flag", {7'd0, irq_flag}, 8'd0);
        chk("R12 hold", {7'd0, scl_hold}, 8'd0);
        chk("R12 ack", {7'd0, ack_out}, 8'd0);
        chk("R12 status", status, 8'hF8);

        // Address sweep: R1 R2 R3 R4, with R11 (sleep) on one own address
        for (int oi = 0; oi < 3; oi++) begin
            for (int g = 0; g < 2; g++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int b = 0; b < 256; b++) begin
                        logic [6:0] own;
                        logic       oh, gh, ev;
                        logic [7:0] code;
                        string      tag;
                        own = (oi == 0) ? 7'h2A : (oi == 1) ? 7'h00 : 7'h7F;
                        own_addr = own; gc_en = g[0]; ack_en = a[0];
                        sleep_mode = (oi == 2);
                        pulse_start();
                        send(b[7:0]);
                        oh = (b[7:1] == own);
                        gh = g[0] && (b == 0) && !oh;
                        ev = a[0] && (oh || gh);
                        code = oh ? (b[0] ? 8'hA8 : 8'h60) : 8'h70;
                        if (oh) tag = a[0] ? "R1" : "R3";
                        else if (b == 0 && g[0]) tag = a[0] ? "R2" : "R3";
                        else if (b == 0) tag = "R2";
                        else tag = "R4";
                        if (oi == 2) tag = {tag, "/R11"};
                        chk({tag, " ack"}, {7'd0, ack_out}, {7'd0, ev});
                        if (ev) begin
                            expect_evt(tag, code);
                            clear_flag(tag);
                            pulse_stop();
                            expect_evt("R6 stop", 8'hA0);
                            clear_flag("R6");
                        end else begin
                            expect_none(tag);
                            send(8'h5A);
                            expect_none({tag, " later byte"});
                            pulse_stop();
                            expect_none({tag, " stop"});
                        end
                    end
                end
            end
        end
        sleep_mode = 1'b0;

        // R5 own-address write data
        own_addr = 7'h2A; gc_en = 1'b0; ack_en = 1'b1;
        pulse_start(); send(8'h54);
        expect_evt("R5 addr", 8'h60); clear_flag("R5");
        send(8'h11);
        chk("R5 data ack", {7'd0, ack_out}, 8'd1);
        expect_evt("R5 data", 8'h80); clear_flag("R5");
        ack_en = 1'b0;
        send(8'h22);
        chk("R5 data nack", {7'd0, ack_out}, 8'd0);
        expect_evt("R5 nack", 8'h88); clear_flag("R5");
        send(8'h33);
        expect_none("R5 after nack");

        // R5 general-call data
        gc_en = 1'b1; ack_en = 1'b1;
        pulse_start(); send(8'h00);
        expect_evt("R5 gc addr", 8'h70); clear_flag("R5");
        send(8'h5A);
        expect_evt("R5 gc data", 8'h90); clear_flag("R5");
        ack_en = 1'b0;
        send(8'hA5);
        chk("R5 gc nack", {7'd0, ack_out}, 8'd0);
        expect_evt("R5 gc nack", 8'h98); clear_flag("R5");
        gc_en = 1'b0; ack_en = 1'b1;

        // R6 repeated START then read address
        pulse_start(); send(8'h54);
        expect_evt("R6 addr", 8'h60); clear_flag("R6");
        pulse_start();
        expect_evt("R6 rstart", 8'hA0); clear_flag("R6");
        send(8'h55);
        expect_evt("R6 read addr", 8'hA8); clear_flag("R6");
        pulse_stop();
        expect_evt("R6 stop", 8'hA0); clear_flag("R6");

        // R7 arbitration lost
        pulse_start(); send(8'h54);
        expect_evt("R7 addr", 8'h60); clear_flag("R7");
        @(negedge clk) arb_lost = 1'b1;
        @(negedge clk) arb_lost = 1'b0;
        expect_evt("R7 arb", 8'h38); clear_flag("R7");
        send(8'h11);
        expect_none("R7 idle after arb");

        // R13 arbitration beats STOP in the same cycle
        pulse_start(); send(8'h54);
        expect_evt("R13 addr", 8'h60); clear_flag("R13");
        @(negedge clk) begin arb_lost = 1'b1; stop_det = 1'b1; end
        @(negedge clk) begin arb_lost = 1'b0; stop_det = 1'b0; end
        expect_evt("R13 arb wins", 8'h38); clear_flag("R13");

        // R11 abort during power-down
        sleep_mode = 1'b1;
        pulse_start();
        @(negedge clk) wake_other = 1'b1;
        @(negedge clk) wake_other = 1'b0;
        send(8'h54);
        chk("R11 no ack after abort", {7'd0, ack_out}, 8'd0);
        expect_none("R11 abort");
        sleep_mode = 1'b0;

        // R10 flag held until cleared; stray clear ignored
        pulse_start(); send(8'h54);
        expect_evt("R10 addr", 8'h60);
        repeat (5) @(negedge clk);
        chk("R10 still held", {7'd0, scl_hold}, 8'd1);
        chk("R10 still set", {7'd0, irq_flag}, 8'd1);
        clear_flag("R10");
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        expect_none("R10 stray clear");
        pulse_stop();
        expect_evt("R10 stop", 8'hA0); clear_flag("R10");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule